// File: doc/BRIEF.md
# Floating-Point Exception Status Controller

This block keeps the exception-related part of a 32-bit floating-point status word and decides, when the arithmetic datapath reports that an operation has completed, whether that operation retires or raises a trap. On retirement it grants the writes of the destination register and of the condition codes, folds the new exception flags into a sticky (accrued) field, and replaces the current-operation field. When an enabled IEEE exception is present, or the datapath reports that it could not finish or does not implement the operation, the block requests a trap and gives a cause code instead. In that case it blocks every architectural write.

Software reads and writes the whole word through a simple write strobe and the always-visible register output. A software write and a completion may arrive in the same cycle. The write then takes effect first, and the completion is held for one cycle and resolved against the freshly written word. The flush-to-zero mode bit of the word is exported to the datapath.

Top module: `fsr_exc_ctrl`

## Requirements
- R1: After reset the status word is all zero, so every trap is disabled and `flush_mode` is 0. `dst_we`, `fcc_we` and `trap_req` are low, and `trap_cause` is 0.
- R2: A software write (`sw_we`=1) loads all 32 bits of `sw_wdata` into the word at the clock edge. This includes bits outside the exception fields, which read back unchanged. `flush_mode` always equals word bit 22.
- R3: A completion without fault flags and with (`op_exc` AND trap-enable field) equal to zero retires. At the edge that samples it: the accrued field becomes its old value OR `op_exc`, the current field becomes `op_exc`, and `dst_we` and `fcc_we` are high for the following cycle.
- R4: A retiring completion with `op_exc`=0 sets the current field to zero and leaves the accrued field unchanged.
- R5: A completion whose exceptions hit an enabled bit raises `trap_req` for one cycle with `trap_cause`=1 (IEEE). The current field is loaded with `op_exc`, the accrued field is unchanged, and `dst_we` and `fcc_we` stay low.
- R6: A completion with `op_unimp`=1 traps with cause 3. Otherwise, a completion with `op_unfin`=1 traps with cause 2. Both take precedence over IEEE exceptions and leave the entire word unchanged.
- R7: Hardware never clears an accrued flag. Only a software write can clear one.
- R8: When `sw_we` and `op_done` are high in the same cycle, the write is applied at that edge with no pulse. The completion is resolved at the next edge against the newly written word.
- R9: Field layout:
  - Trap-enable field is bits 27:23.
  - Accrued field is bits 9:5.
  - Current field is bits 4:0.
  - Each of these fields, and `op_exc`, is ordered invalid, overflow, underflow, divide-by-zero, inexact from its most significant bit down.
  - The non-standard (flush-to-zero) mode bit is bit 22.
- R10: Each resolved completion produces exactly one single-cycle pulse: either the retire pair or a trap, never both. `trap_cause` is 0 whenever `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | An operation completed this cycle |
| op_exc | input | 5 | IEEE exceptions of the completing operation (R9 order) |
| op_unfin | input | 1 | Completing operation could not be finished in hardware |
| op_unimp | input | 1 | Completing operation is not implemented in hardware |
| sw_we | input | 1 | Software write strobe for the status word |
| sw_wdata | input | 32 | Software write data |
| fsr_q | output | 32 | Current status word |
| dst_we | output | 1 | Destination register write grant (one cycle) |
| fcc_we | output | 1 | Condition code write grant (one cycle) |
| trap_req | output | 1 | Trap request pulse |
| trap_cause | output | 2 | 0 none, 1 IEEE, 2 unfinished, 3 unimplemented |
| flush_mode | output | 1 | Non-standard flush-to-zero mode to the datapath |

## Verification
The bench targets the following corner cases and the failure each one would expose.
- **Enabled and disabled exceptions together.** A design that tested for any exception instead of an enabled one would trap on a masked inexact.
- **Fault flags raised alongside IEEE flags.** A design that let the IEEE path win, or that loaded the current field on a fault trap, would corrupt the word.
- **Collision of a software write that changes the enable mask with a completion.** A design that dropped the held completion, or judged it against the old mask, would retire where a trap is due.
- **Long random streams.** These catch any hardware clearing of an accrued flag, and any cycle where a retire grant and a trap appear together.

// File: rtl/fsr_exc_pkg.sv
package fsr_exc_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_IEEE  = 2'd1,
      CAUSE_UNFIN = 2'd2,
      CAUSE_UNIMP = 2'd3
   } trap_cause_e;

   typedef struct packed {
      logic unimp;
      logic unfin;
   } fault_t;

endpackage

// File: rtl/fsr_exc_hold.sv
// Holds one completion that collided with a software write.
module fsr_exc_hold
   import fsr_exc_pkg::*;
#(
   parameter int EXC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [EXC_W-1:0] in_exc,
   input  fault_t           in_flt,
   input  logic             sw_we,
   output logic             app_vld,
   output logic [EXC_W-1:0] app_exc,
   output fault_t           app_flt
);
   localparam int EVT_W = EXC_W + $bits(fault_t);

   logic             pend_vld;
   logic [EVT_W-1:0] pend_evt;
   logic [EVT_W-1:0] in_evt;
   logic [EVT_W-1:0] sel_evt;
   logic             sel_vld;

   assign in_evt  = {in_flt, in_exc};
   assign sel_vld = pend_vld | in_vld;
   assign sel_evt = pend_vld ? pend_evt : in_evt;

   assign app_vld = sel_vld & ~sw_we;
   assign app_exc = sel_evt[EXC_W-1:0];
   assign app_flt = fault_t'(sel_evt[EVT_W-1:EXC_W]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld <= 1'b0;
         pend_evt <= '0;
      end else if (sw_we) begin
         // the oldest event waits behind the write
         pend_vld <= sel_vld;
         pend_evt <= sel_evt;
      end else begin
         // a held event resolves now; a new arrival takes its slot
         pend_vld <= pend_vld & in_vld;
         pend_evt <= in_evt;
      end
   end
endmodule

// File: rtl/fsr_exc_decide.sv
// Retire-or-trap verdict for one completion.
module fsr_exc_decide
   import fsr_exc_pkg::*;
#(
   parameter int EXC_W = 5
) (
   input  logic             vld,
   input  logic [EXC_W-1:0] exc,
   input  fault_t           flt,
   input  logic [EXC_W-1:0] tem,
   input  logic [EXC_W-1:0] aexc,
   output logic             retire,
   output trap_cause_e      cause,
   output logic             wr_aexc,
   output logic             wr_cexc,
   output logic [EXC_W-1:0] new_aexc,
   output logic [EXC_W-1:0] new_cexc
);
   logic hit;
   assign hit = |(exc & tem);

   always_comb begin
      retire   = 1'b0;
      cause    = CAUSE_NONE;
      wr_aexc  = 1'b0;
      wr_cexc  = 1'b0;
      new_aexc = aexc | exc;
      new_cexc = exc;
      if (vld) begin
         if (flt.unimp) begin
            cause = CAUSE_UNIMP;
         end else if (flt.unfin) begin
            cause = CAUSE_UNFIN;
         end else if (hit) begin
            cause   = CAUSE_IEEE;
            wr_cexc = 1'b1;
         end else begin
            retire  = 1'b1;
            wr_aexc = 1'b1;
            wr_cexc = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fsr_exc_word.sv
// Status word storage; per-bit source picked by field membership.
module fsr_exc_word #(
   parameter int REG_W    = 32,
   parameter int EXC_W    = 5,
   parameter int AEXC_LSB = 5,
   parameter int CEXC_LSB = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [REG_W-1:0] sw_wdata,
   input  logic             wr_aexc,
   input  logic             wr_cexc,
   input  logic [EXC_W-1:0] new_aexc,
   input  logic [EXC_W-1:0] new_cexc,
   output logic [REG_W-1:0] word_q
);
   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      localparam bit IN_A = (b >= AEXC_LSB) && (b < AEXC_LSB + EXC_W);
      localparam bit IN_C = (b >= CEXC_LSB) && (b < CEXC_LSB + EXC_W);
      if (IN_A) begin : g_acc
         always_ff @(posedge clk) begin
            if (!rst_n)       word_q[b] <= 1'b0;
            else if (sw_we)   word_q[b] <= sw_wdata[b];
            else if (wr_aexc) word_q[b] <= new_aexc[b-AEXC_LSB];
         end
      end else if (IN_C) begin : g_cur
         always_ff @(posedge clk) begin
            if (!rst_n)       word_q[b] <= 1'b0;
            else if (sw_we)   word_q[b] <= sw_wdata[b];
            else if (wr_cexc) word_q[b] <= new_cexc[b-CEXC_LSB];
         end
      end else begin : g_sw
         always_ff @(posedge clk) begin
            if (!rst_n)     word_q[b] <= 1'b0;
            else if (sw_we) word_q[b] <= sw_wdata[b];
         end
      end
   end
endmodule

// File: rtl/fsr_exc_ctrl.sv
module fsr_exc_ctrl
   import fsr_exc_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int EXC_W    = 5,
   parameter int TEM_LSB  = 23,
   parameter int NS_BIT   = 22,
   parameter int AEXC_LSB = 5,
   parameter int CEXC_LSB = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_done,
   input  logic [EXC_W-1:0] op_exc,
   input  logic             op_unfin,
   input  logic             op_unimp,
   input  logic             sw_we,
   input  logic [REG_W-1:0] sw_wdata,
   output logic [REG_W-1:0] fsr_q,
   output logic             dst_we,
   output logic             fcc_we,
   output logic             trap_req,
   output logic [1:0]       trap_cause,
   output logic             flush_mode
);
   localparam int TEM_MSB  = TEM_LSB + EXC_W - 1;
   localparam int AEXC_MSB = AEXC_LSB + EXC_W - 1;
   localparam int CEXC_MSB = CEXC_LSB + EXC_W - 1;

   if (TEM_MSB >= REG_W || AEXC_MSB >= REG_W || CEXC_MSB >= REG_W || NS_BIT >= REG_W)
   begin : g_bad_fit
      $error("fsr_exc_ctrl: a field lies outside the word");
   end
   if ((AEXC_LSB <= CEXC_MSB && CEXC_LSB <= AEXC_MSB) ||
       (TEM_LSB <= AEXC_MSB && AEXC_LSB <= TEM_MSB) ||
       (TEM_LSB <= CEXC_MSB && CEXC_LSB <= TEM_MSB) ||
       (NS_BIT >= TEM_LSB && NS_BIT <= TEM_MSB))
   begin : g_bad_overlap
      $error("fsr_exc_ctrl: fields overlap");
   end

   logic             app_vld;
   logic [EXC_W-1:0] app_exc;
   fault_t           app_flt;
   fault_t           in_flt;
   logic             retire;
   trap_cause_e      cause;
   logic             wr_aexc, wr_cexc;
   logic [EXC_W-1:0] new_aexc, new_cexc;

   assign in_flt = '{unimp: op_unimp, unfin: op_unfin};

   fsr_exc_hold #(.EXC_W(EXC_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (op_done),
      .in_exc  (op_exc),
      .in_flt  (in_flt),
      .sw_we   (sw_we),
      .app_vld (app_vld),
      .app_exc (app_exc),
      .app_flt (app_flt)
   );

   fsr_exc_decide #(.EXC_W(EXC_W)) u_decide (
      .vld      (app_vld),
      .exc      (app_exc),
      .flt      (app_flt),
      .tem      (fsr_q[TEM_MSB:TEM_LSB]),
      .aexc     (fsr_q[AEXC_MSB:AEXC_LSB]),
      .retire   (retire),
      .cause    (cause),
      .wr_aexc  (wr_aexc),
      .wr_cexc  (wr_cexc),
      .new_aexc (new_aexc),
      .new_cexc (new_cexc)
   );

   fsr_exc_word #(
      .REG_W    (REG_W),
      .EXC_W    (EXC_W),
      .AEXC_LSB (AEXC_LSB),
      .CEXC_LSB (CEXC_LSB)
   ) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (sw_we),
      .sw_wdata (sw_wdata),
      .wr_aexc  (wr_aexc),
      .wr_cexc  (wr_cexc),
      .new_aexc (new_aexc),
      .new_cexc (new_cexc),
      .word_q   (fsr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_we     <= 1'b0;
         fcc_we     <= 1'b0;
         trap_req   <= 1'b0;
         trap_cause <= 2'd0;
      end else begin
         dst_we     <= retire;
         fcc_we     <= retire;
         trap_req   <= (cause != CAUSE_NONE);
         trap_cause <= cause;
      end
   end

   assign flush_mode = fsr_q[NS_BIT];
endmodule

// File: rtl/fsr_exc_chk.sv
module fsr_exc_chk #(
   parameter int REG_W    = 32,
   parameter int EXC_W    = 5,
   parameter int TEM_LSB  = 23,
   parameter int AEXC_LSB = 5,
   parameter int CEXC_LSB = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_we,
   input logic [REG_W-1:0] sw_wdata,
   input logic [REG_W-1:0] fsr_q,
   input logic             dst_we,
   input logic             trap_req,
   input logic [1:0]       trap_cause
);
   logic [EXC_W-1:0] tem, aexc, cexc;
   assign tem  = fsr_q[TEM_LSB  +: EXC_W];
   assign aexc = fsr_q[AEXC_LSB +: EXC_W];
   assign cexc = fsr_q[CEXC_LSB +: EXC_W];

   AST_RETIRE_OR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(dst_we && trap_req)); // R10
   AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |-> trap_cause == 2'd0); // R10
   AST_ACCRUED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sw_we) |-> ((aexc & $past(aexc)) == $past(aexc))); // R7
   AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && trap_cause[1] && !$past(sw_we)) |-> fsr_q == $past(fsr_q)); // R6
   AST_IEEE_CAUSE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && trap_cause == 2'd1) |-> (cexc & tem) != '0); // R5
   AST_RETIRE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we |-> (cexc & tem) == '0); // R3
   AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_we) |-> (fsr_q == $past(sw_wdata) && !dst_we && !trap_req)); // R8
endmodule

bind fsr_exc_ctrl fsr_exc_chk #(
   .REG_W    (REG_W),
   .EXC_W    (EXC_W),
   .TEM_LSB  (TEM_LSB),
   .AEXC_LSB (AEXC_LSB),
   .CEXC_LSB (CEXC_LSB)
) u_fsr_exc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_we      (sw_we),
   .sw_wdata   (sw_wdata),
   .fsr_q      (fsr_q),
   .dst_we     (dst_we),
   .trap_req   (trap_req),
   .trap_cause (trap_cause)
);

// File: tb/test_fsr_exc_ctrl.sv
module test_fsr_exc_ctrl;
   localparam int CLK_P = 10;

   // bit positions (R9)
   localparam int NV = 4, OF = 3, UF = 2, DZ = 1, NX = 0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_done = 1'b0;
   logic [4:0]  op_exc = '0;
   logic        op_unfin = 1'b0;
   logic        op_unimp = 1'b0;
   logic        sw_we = 1'b0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] fsr_q;
   logic        dst_we, fcc_we, trap_req, flush_mode;
   logic [1:0]  trap_cause;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   fsr_exc_ctrl i_fsr_exc_ctrl (
      .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_exc(op_exc),
      .op_unfin(op_unfin), .op_unimp(op_unimp), .sw_we(sw_we),
      .sw_wdata(sw_wdata), .fsr_q(fsr_q), .dst_we(dst_we), .fcc_we(fcc_we),
      .trap_req(trap_req), .trap_cause(trap_cause), .flush_mode(flush_mode)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_fsr;
   logic        e_we, e_trap;
   logic [1:0]  e_cause;
   logic [6:0]  pq[$];   // {unimp, unfin, exc}

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fsr = '0; e_we = 0; e_trap = 0; e_cause = 0;
         pq.delete();
      end else begin
         e_we = 0; e_trap = 0; e_cause = 0;
         if (op_done) pq.push_back({op_unimp, op_unfin, op_exc});
         if (sw_we) begin
            m_fsr = sw_wdata;
            while (pq.size() > 1) void'(pq.pop_back());
         end else if (pq.size() > 0) begin
            logic [6:0] ev;
            ev = pq.pop_front();
            if (ev[6]) begin
               e_trap = 1; e_cause = 3;
            end else if (ev[5]) begin
               e_trap = 1; e_cause = 2;
            end else if ((ev[4:0] & m_fsr[27:23]) != 0) begin
               e_trap = 1; e_cause = 1;
               m_fsr[4:0] = ev[4:0];
            end else begin
               e_we = 1;
               m_fsr[9:5] = m_fsr[9:5] | ev[4:0];
               m_fsr[4:0] = ev[4:0];
            end
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "fsr_q", fsr_q, m_fsr);
      chk(tag, "dst_we", {31'd0, dst_we}, {31'd0, e_we});
      chk(tag, "fcc_we", {31'd0, fcc_we}, {31'd0, e_we});
      chk(tag, "trap_req", {31'd0, trap_req}, {31'd0, e_trap});
      chk(tag, "trap_cause", {30'd0, trap_cause}, {30'd0, e_cause});
      chk(tag, "flush_mode", {31'd0, flush_mode}, {31'd0, m_fsr[22]});
   endtask

   // one clock: drive at negedge, compare at next negedge
   task automatic cyc(input string tag, input bit done, input logic [4:0] exc,
                      input bit unfin, input bit unimp, input bit we,
                      input logic [31:0] wd);
      op_done = done; op_exc = exc; op_unfin = unfin; op_unimp = unimp;
      sw_we = we; sw_wdata = wd;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input string tag);
      cyc(tag, 0, 5'd0, 0, 0, 0, 32'd0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      idle("R1");
      chk("R1", "reset word", fsr_q, 32'd0);

      // R3 retire with masked exceptions, R9 field order
      cyc("R3", 1, 5'b1 << OF | 5'b1 << NX, 0, 0, 0, 0);
      chk("R9", "accrued overflow bit 8", {31'd0, fsr_q[8]}, 32'd1);
      idle("R3");
      // R4 clean op zeroes current field
      cyc("R4", 1, 5'd0, 0, 0, 0, 0);
      chk("R4", "current cleared", {27'd0, fsr_q[4:0]}, 32'd0);
      idle("R4");

      // R2 software write incl. spare bits and mode bit; enable invalid
      cyc("R2", 0, 0, 0, 0, 1, 32'hC040_1C00 | (32'd1 << 27) | (32'd1 << 22));
      chk("R2", "flush mode", {31'd0, flush_mode}, 32'd1);
      // R5 enabled invalid traps
      cyc("R5", 1, 5'b1 << NV | 5'b1 << NX, 0, 0, 0, 0);
      chk("R5", "ieee cause", {30'd0, trap_cause}, 32'd1);
      // R3 inexact only: not enabled, retires
      cyc("R3", 1, 5'b1 << NX, 0, 0, 0, 0);
      // R6 faults
      cyc("R6", 1, 5'b1 << NV, 1, 0, 0, 0);
      chk("R6", "unfinished cause", {30'd0, trap_cause}, 32'd2);
      cyc("R6", 1, 5'b1 << DZ, 1, 1, 0, 0);
      chk("R6", "unimplemented cause", {30'd0, trap_cause}, 32'd3);
      cyc("R6", 1, 5'd0, 0, 1, 0, 0);
      idle("R6");

      // R7 accrued grows, cleared only by software
      cyc("R7", 0, 0, 0, 0, 1, 32'd0);
      cyc("R7", 1, 5'b1 << UF, 0, 0, 0, 0);
      cyc("R7", 1, 5'b1 << DZ, 0, 0, 0, 0);
      cyc("R7", 1, 5'd0, 0, 0, 0, 0);
      chk("R7", "accrued kept", {27'd0, fsr_q[9:5]}, {27'd0, 5'b00110});
      cyc("R7", 0, 0, 0, 0, 1, 32'd0);
      chk("R7", "software clear", {27'd0, fsr_q[9:5]}, 32'd0);

      // R8 collision: write enables overflow, same-cycle overflow op traps next
      cyc("R8", 1, 5'b1 << OF, 0, 0, 1, 32'd1 << 26);
      chk("R8", "no pulse on write edge", {31'd0, trap_req | dst_we}, 32'd0);
      idle("R8");
      chk("R8", "deferred trap", {31'd0, trap_req}, 32'd1);
      // R8 collision followed by a back-to-back op
      cyc("R8", 1, 5'b1 << NX, 0, 0, 1, 32'd0);
      cyc("R8", 1, 5'b1 << UF, 0, 0, 0, 0);
      cyc("R8", 0, 0, 0, 0, 0, 0);
      idle("R8");

      // R10 back-to-back completions, then random stream
      for (int i = 0; i < 4; i++) cyc("R10", 1, 5'(i * 7), 0, 0, 0, 0);
      for (int i = 0; i < 2000; i++) begin
         bit d, w, uf, ui;
         d  = ($urandom % 3) != 0;
         w  = ($urandom % 6) == 0;
         uf = ($urandom % 8) == 0;
         ui = ($urandom % 10) == 0;
         if (w && pq.size() > 0) d = 0;
         cyc("R10", d, 5'($urandom), uf, ui, w,
             $urandom & 32'hFFC0_FFFF | (($urandom % 4) == 0 ? 32'h0040_0000 : 32'd0));
      end
      idle("R10");

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule